// File: doc/BRIEF.md
# Serial NOR Flash Instruction Sequencer

This block sits between a flash controller and a single-lane serial NOR device. It sends short custom instructions over SPI mode 0 and takes care of the device's busy state, so the controller does not have to handle it. A pulse on `act_req` starts a status-poll loop with no further command. Each loop pass is one chip-select frame: opcode 0x05, then one status byte. The loop ends when the write-in-progress flag reads clear, and the block then pulses `ready_evt`. If the device never reports not-busy within a bounded time, for example because it sleeps in deep power-down and ignores everything but the release opcode, the block stops polling and pulses `timeout_err` instead.

A pulse on `cmd_req` launches a custom instruction. The instruction is described by an opcode, a total byte length, the levels for IO2 and IO3, a wait flag and a write-enable flag. When the wait flag is set, the block polls first. When the write-enable flag is set, a one-byte 0x06 frame follows. Last comes the instruction frame itself. No poll follows it, and `ready_evt` fires as soon as the last byte has been shifted. After the release opcode 0xAB, chip select is held high for at least 30 µs before any further frame. This gives a sleeping device time to wake.

The FSM states are IDLE, SPACE, POLL_OP, POLL_ST, WREN_OP, CMD_OP and CMD_FILL.
- IDLE moves to SPACE when it accepts a request. It also records the first frame kind: a poll, a write-enable or the instruction.
- SPACE holds until the deselect timer reaches zero, then opens the chosen frame in POLL_OP, WREN_OP or CMD_OP.
- POLL_OP moves to POLL_ST after the opcode byte.
- POLL_ST closes the frame and takes one of four paths:
  - it returns to SPACE for another poll while the device is busy;
  - it moves on to the write-enable or instruction frame once the device is clear;
  - it finishes in IDLE with a ready event for an activation;
  - it finishes in IDLE with an error on timeout.
- WREN_OP returns to SPACE with the instruction frame pending.
- CMD_OP either finishes in IDLE or moves to CMD_FILL for the remaining bytes.
- CMD_FILL loops until the last byte and then finishes in IDLE.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `cs_n` is 1, `sck` is 0, `busy`, `ready_evt` and `timeout_err` are 0, and `io2` and `io3` are 1.
- R2: The serial clock follows SPI mode 0. `sck` is low whenever `cs_n` is high. Every high phase of `sck` lasts SCK_HALF_CYC clock cycles. `mosi` carries each byte MSB first and is stable while `sck` is high.
- R3: An activation sends one or more frames. Each frame holds exactly two bytes: opcode 0x05 and a status byte read on `miso`. Polling repeats until bit 0 of the status byte (the write-in-progress flag) reads 0. A single-cycle `ready_evt` then follows.
- R4: With the wait flag set, the poll frames of R3 come before the instruction frame. No frame follows the instruction frame, and `ready_evt` fires right after its last byte.
- R5: With the write-enable flag set, a separate one-byte frame with opcode 0x06 is sent after any poll frames and before the instruction frame.
- R6: The instruction frame sends the opcode followed by filler bytes of 0x00, `cmd_len` bytes in total. A `cmd_len` of 0 is treated as 1.
- R7: A poll whose status byte shows busy, read once POLL_TMO_CYC cycles have passed since the request was accepted, ends the operation. The block then pulses `timeout_err` for one cycle and does not pulse `ready_evt`.
- R8: After an instruction frame with opcode 0xAB, `cs_n` stays high for at least 30 µs before the next frame, with the time counted in cycles of a CLK_HZ clock.
- R9: Between any two frames, `cs_n` stays high for at least two serial clock periods (4·SCK_HALF_CYC cycles).
- R10: `busy` is 1 from the cycle after a request is accepted. It falls in the same cycle as the `ready_evt` or `timeout_err` pulse, each of which lasts one cycle. `cs_n` is low only while `busy` is 1.
- R11: Requests that arrive while `busy` is 1 are ignored. When `act_req` and `cmd_req` are pulsed together, the activation wins.
- R12: While `busy` is 1, `io2` and `io3` carry the levels latched from `cmd_io2` and `cmd_io3`, or 1 for an activation. While `busy` is 0, both are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_req | input | 1 | Start the busy poll (activation) |
| cmd_req | input | 1 | Start a custom instruction |
| cmd_opcode | input | 8 | Instruction opcode |
| cmd_len | input | LEN_W | Total instruction bytes including opcode |
| cmd_io2 | input | 1 | IO2 level held during the instruction |
| cmd_io3 | input | 1 | IO3 level held during the instruction |
| cmd_wip_wait | input | 1 | Poll until not busy before the instruction |
| cmd_wren | input | 1 | Send write-enable before the instruction |
| sck | output | 1 | Serial clock, mode 0 |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |
| io2 | output | 1 | IO2 static level |
| io3 | output | 1 | IO3 static level |
| busy | output | 1 | Operation in progress |
| ready_evt | output | 1 | One-cycle completion event |
| timeout_err | output | 1 | One-cycle poll timeout event |

## Verification
The bench builds the block with CLK_HZ at 10 MHz, SCK_HALF_CYC at 2 and POLL_TMO_CYC at 600. The wake quiet time then comes to 300 cycles. A poll frame takes about 70 cycles, so a device model held in deep power-down reaches the timeout after roughly nine polls, while busy counts of up to three polls still complete normally. A behavioural flash model that answers 0x05, sleeps on 0xB9 and wakes on 0xAB lets the bench check frame ordering, gap lengths and the quiet time after a wake on real frame boundaries.

// File: rtl/fseq_pkg.sv
package fseq_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SPACE,
        S_POLL_OP,
        S_POLL_ST,
        S_WREN_OP,
        S_CMD_OP,
        S_CMD_FILL
    } seq_state_t;

    typedef enum logic [1:0] {
        FR_POLL,
        FR_WREN,
        FR_CMD
    } frame_kind_t;

    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_WR_ENABLE = 8'h06;
    localparam logic [7:0] OP_WAKE      = 8'hAB;
    localparam logic [7:0] OP_FILLER    = 8'h00;
    localparam logic [7:0] WIP_MASK     = 8'h01;

endpackage

// File: rtl/fseq_byte_shift.sv
module fseq_byte_shift #(
    parameter int HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       done,
    output logic [7:0] rx_byte
);

    localparam int CW = $clog2(HALF_CYC + 1);
    localparam logic [CW-1:0] PH_LAST = CW'(HALF_CYC - 1);

    logic          active_q;
    logic          sck_q;
    logic          done_q;
    logic [CW-1:0] ph_q;
    logic [2:0]    bit_q;
    logic [7:0]    sh_q;
    logic [7:0]    rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            ph_q     <= '0;
            bit_q    <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= tx_byte;
                    ph_q     <= '0;
                    bit_q    <= '0;
                    sck_q    <= 1'b0;
                end
            end else if (ph_q == PH_LAST) begin
                ph_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        sh_q  <= {sh_q[6:0], 1'b0};
                    end
                end
            end else begin
                ph_q <= ph_q + CW'(1);
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = sh_q[7];
    assign done    = done_q;
    assign rx_byte = rx_q;

endmodule

// File: rtl/fseq_space_timer.sv
module fseq_space_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             zero
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - WIDTH'(1);
        end
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fseq_pkg::*;
#(
    parameter int CLK_HZ       = 250_000_000,
    parameter int SCK_HALF_CYC = 2,
    parameter int POLL_TMO_CYC = 1_000_000,
    parameter int LEN_W        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_req,
    input  logic             cmd_req,
    input  logic [7:0]       cmd_opcode,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic             cmd_io2,
    input  logic             cmd_io3,
    input  logic             cmd_wip_wait,
    input  logic             cmd_wren,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             io2,
    output logic             io3,
    output logic             busy,
    output logic             ready_evt,
    output logic             timeout_err
);

    localparam int GAP_CYC   = 4 * SCK_HALF_CYC;
    localparam int QUIET_CYC = ((CLK_HZ / 1000) * 30 + 999) / 1000;
    localparam int SPACE_MAX = (QUIET_CYC > GAP_CYC) ? QUIET_CYC : GAP_CYC;
    localparam int SPC_W     = $clog2(SPACE_MAX + 1);
    localparam int TMO_W     = $clog2(POLL_TMO_CYC + 1);
    localparam logic [TMO_W-1:0] TMO_LIMIT = TMO_W'(POLL_TMO_CYC);
    localparam logic [LEN_W-1:0] LEN_ONE   = LEN_W'(1);

    seq_state_t       state_q, state_d;
    frame_kind_t      nxt_q, nxt_d;
    logic [LEN_W-1:0] rem_q, rem_d;

    logic [7:0]       op_q;
    logic [LEN_W-1:0] len_q;
    logic             io2_q, io3_q, wren_q, act_q;
    logic             busy_q, ready_q, err_q, cs_n_q;
    logic [TMO_W-1:0] tmo_q;

    logic             sh_start;
    logic [7:0]       sh_tx;
    logic             sh_done;
    logic [7:0]       sh_rx;
    logic             spc_zero;
    logic [SPC_W-1:0] spc_val;

    logic take_act, take_cmd, frame_go, frame_end, fin_ok, fin_err;
    logic stat_busy, tmo_hit, wake_frame;

    assign stat_busy  = |(sh_rx & WIP_MASK);
    assign tmo_hit    = (tmo_q >= TMO_LIMIT);
    assign wake_frame = (state_q == S_CMD_OP || state_q == S_CMD_FILL) && (op_q == OP_WAKE);
    assign spc_val    = wake_frame ? SPC_W'(QUIET_CYC) : SPC_W'(GAP_CYC);

    fseq_byte_shift #(
        .HALF_CYC (SCK_HALF_CYC)
    ) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (sh_start),
        .tx_byte (sh_tx),
        .miso    (miso),
        .sck     (sck),
        .mosi    (mosi),
        .done    (sh_done),
        .rx_byte (sh_rx)
    );

    fseq_space_timer #(
        .WIDTH (SPC_W)
    ) space_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (frame_end),
        .load_val (spc_val),
        .zero     (spc_zero)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            nxt_q   <= FR_POLL;
            rem_q   <= '0;
        end else begin
            state_q <= state_d;
            nxt_q   <= nxt_d;
            rem_q   <= rem_d;
        end
    end

    // Next state and per-cycle strobes
    always_comb begin
        state_d   = state_q;
        nxt_d     = nxt_q;
        rem_d     = rem_q;
        take_act  = 1'b0;
        take_cmd  = 1'b0;
        frame_go  = 1'b0;
        frame_end = 1'b0;
        fin_ok    = 1'b0;
        fin_err   = 1'b0;
        sh_start  = 1'b0;
        sh_tx     = OP_FILLER;
        unique case (state_q)
            S_IDLE: begin
                if (act_req) begin
                    take_act = 1'b1;
                    nxt_d    = FR_POLL;
                    state_d  = S_SPACE;
                end else if (cmd_req) begin
                    take_cmd = 1'b1;
                    if (cmd_wip_wait)  nxt_d = FR_POLL;
                    else if (cmd_wren) nxt_d = FR_WREN;
                    else               nxt_d = FR_CMD;
                    state_d = S_SPACE;
                end
            end
            S_SPACE: begin
                if (spc_zero) begin
                    frame_go = 1'b1;
                    sh_start = 1'b1;
                    unique case (nxt_q)
                        FR_POLL: begin
                            sh_tx   = OP_RD_STATUS;
                            state_d = S_POLL_OP;
                        end
                        FR_WREN: begin
                            sh_tx   = OP_WR_ENABLE;
                            state_d = S_WREN_OP;
                        end
                        default: begin
                            sh_tx   = op_q;
                            state_d = S_CMD_OP;
                        end
                    endcase
                end
            end
            S_POLL_OP: begin
                if (sh_done) begin
                    sh_start = 1'b1;
                    sh_tx    = OP_FILLER;
                    state_d  = S_POLL_ST;
                end
            end
            S_POLL_ST: begin
                if (sh_done) begin
                    frame_end = 1'b1;
                    if (!stat_busy) begin
                        if (act_q) begin
                            fin_ok  = 1'b1;
                            state_d = S_IDLE;
                        end else begin
                            nxt_d   = wren_q ? FR_WREN : FR_CMD;
                            state_d = S_SPACE;
                        end
                    end else if (tmo_hit) begin
                        fin_err = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        nxt_d   = FR_POLL;
                        state_d = S_SPACE;
                    end
                end
            end
            S_WREN_OP: begin
                if (sh_done) begin
                    frame_end = 1'b1;
                    nxt_d     = FR_CMD;
                    state_d   = S_SPACE;
                end
            end
            S_CMD_OP: begin
                if (sh_done) begin
                    if (len_q <= LEN_ONE) begin
                        frame_end = 1'b1;
                        fin_ok    = 1'b1;
                        state_d   = S_IDLE;
                    end else begin
                        sh_start = 1'b1;
                        sh_tx    = OP_FILLER;
                        rem_d    = len_q - LEN_ONE;
                        state_d  = S_CMD_FILL;
                    end
                end
            end
            S_CMD_FILL: begin
                if (sh_done) begin
                    if (rem_q == LEN_ONE) begin
                        frame_end = 1'b1;
                        fin_ok    = 1'b1;
                        state_d   = S_IDLE;
                    end else begin
                        sh_start = 1'b1;
                        sh_tx    = OP_FILLER;
                        rem_d    = rem_q - LEN_ONE;
                    end
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // Registered outputs and request latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            len_q   <= LEN_ONE;
            io2_q   <= 1'b1;
            io3_q   <= 1'b1;
            wren_q  <= 1'b0;
            act_q   <= 1'b0;
            busy_q  <= 1'b0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            cs_n_q  <= 1'b1;
            tmo_q   <= '0;
        end else begin
            ready_q <= fin_ok;
            err_q   <= fin_err;
            if (take_act || take_cmd) begin
                busy_q <= 1'b1;
                act_q  <= take_act;
                op_q   <= cmd_opcode;
                len_q  <= (cmd_len == '0) ? LEN_ONE : cmd_len;
                io2_q  <= take_act ? 1'b1 : cmd_io2;
                io3_q  <= take_act ? 1'b1 : cmd_io3;
                wren_q <= cmd_wren;
                tmo_q  <= '0;
            end else begin
                if (fin_ok || fin_err) busy_q <= 1'b0;
                if (busy_q && !tmo_hit) tmo_q <= tmo_q + TMO_W'(1);
            end
            if (frame_go)       cs_n_q <= 1'b0;
            else if (frame_end) cs_n_q <= 1'b1;
        end
    end

    assign cs_n        = cs_n_q;
    assign busy        = busy_q;
    assign ready_evt   = ready_q;
    assign timeout_err = err_q;
    assign io2         = busy_q ? io2_q : 1'b1;
    assign io3         = busy_q ? io3_q : 1'b1;

endmodule

// File: rtl/fseq_chk.sv
module fseq_chk (
    input logic clk,
    input logic rst_n,
    input logic sck,
    input logic cs_n,
    input logic mosi,
    input logic busy,
    input logic ready_evt,
    input logic timeout_err
);

    a_r2_sck_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r2_mosi_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r10_ready_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ready_evt |-> (!busy && $past(busy)));

    a_r10_err_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> (!busy && $past(busy)));

    a_r10_ready_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ready_evt |=> !ready_evt);

    a_r7_err_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !(ready_evt && timeout_err));

    a_r10_frame_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> busy);

endmodule

bind flash_cmd_seq fseq_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck         (sck),
    .cs_n        (cs_n),
    .mosi        (mosi),
    .busy        (busy),
    .ready_evt   (ready_evt),
    .timeout_err (timeout_err)
);

// File: tb/flash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb_top;

    localparam int CLK_HZ   = 10_000_000;
    localparam int HALF     = 2;
    localparam int TMO      = 600;
    localparam int LW       = 4;
    localparam int MIN_GAP  = 4 * HALF;
    localparam int MIN_WAKE = 300;   // 30 us at 10 MHz
    localparam int NV       = 7;

    // {kind, opcode, len, wait, wren, io2, io3, busy_polls}
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd0},
        {1'b0, 8'h00, 4'd0, 1'b0, 1'b0, 1'b1, 1'b1, 4'd3},
        {1'b1, 8'h20, 4'd4, 1'b1, 1'b1, 1'b1, 1'b1, 4'd2},
        {1'b1, 8'h9F, 4'd1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd0},
        {1'b1, 8'hC7, 4'd1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0},
        {1'b1, 8'h02, 4'd0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd1},
        {1'b1, 8'h03, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1, 4'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_req = 1'b0, cmd_req = 1'b0;
    logic [7:0] cmd_opcode = 8'h00;
    logic [LW-1:0] cmd_len = '0;
    logic cmd_io2 = 1'b1, cmd_io3 = 1'b1, cmd_wip_wait = 1'b0, cmd_wren = 1'b0;
    logic sck, cs_n, mosi, io2, io3, busy, ready_evt, timeout_err;
    logic miso = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .CLK_HZ       (CLK_HZ),
        .SCK_HALF_CYC (HALF),
        .POLL_TMO_CYC (TMO),
        .LEN_W        (LW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .cmd_req(cmd_req),
        .cmd_opcode(cmd_opcode), .cmd_len(cmd_len), .cmd_io2(cmd_io2), .cmd_io3(cmd_io3),
        .cmd_wip_wait(cmd_wip_wait), .cmd_wren(cmd_wren), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso), .io2(io2), .io3(io3), .busy(busy),
        .ready_evt(ready_evt), .timeout_err(timeout_err)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input string what, input int act, input int lim);
        n_chk++;
        if (act < lim) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected >= %0d", req, what, act, lim);
        end
    endtask

    // ---------------- flash model and frame log ----------------
    int cyc = 0;
    always @(posedge clk) cyc++;

    int nfr = 0;
    int fr_op [256];
    int fr_nb [256];
    int fr_gap[256];
    int fr_io [256];
    int last_rise = 0;
    bit in_frame = 0;
    int bitk = 0, nb = 0;
    logic [7:0] cur_byte = 0, cur_op = 0, stat = 0;
    int busy_left = 0;
    bit asleep = 0;

    always @(negedge cs_n) begin
        in_frame = 1;
        bitk = 0; nb = 0; cur_byte = 0; cur_op = 0; miso = 1'b0;
        fr_gap[nfr] = cyc - last_rise;
        fr_io[nfr]  = {30'd0, io2, io3};
    end

    always @(posedge sck) if (!cs_n) begin
        cur_byte = {cur_byte[6:0], mosi};
        bitk++;
        if (bitk % 8 == 0) begin
            nb++;
            if (bitk == 8) begin
                cur_op = cur_byte;
                stat = asleep ? 8'hFF : {7'd0, busy_left != 0};
            end
        end
    end

    always @(negedge sck) if (!cs_n && bitk >= 8 && bitk < 16) miso = stat[15 - bitk];

    always @(posedge cs_n) if (in_frame) begin
        in_frame = 0;
        fr_op[nfr] = int'(cur_op);
        fr_nb[nfr] = nb;
        if (cur_op == 8'hAB) asleep = 0;
        else if (!asleep) begin
            if (cur_op == 8'hB9) asleep = 1;
            if (cur_op == 8'h05 && busy_left > 0) busy_left--;
        end
        last_rise = cyc;
        if (nfr < 255) nfr++;
    end

    // ---------------- event counters ----------------
    int rdy_cnt = 0, err_cnt = 0, wide_cnt = 0;
    bit rdy_prev = 0, err_prev = 0;
    int run = 0, bad_run = 0, seen_runs = 0;

    always @(negedge clk) begin
        if (ready_evt) begin rdy_cnt++; if (rdy_prev) wide_cnt++; end
        if (timeout_err) begin err_cnt++; if (err_prev) wide_cnt++; end
        rdy_prev = ready_evt;
        err_prev = timeout_err;
        if (sck) run++;
        else if (run != 0) begin
            if (run != HALF) bad_run++;
            seen_runs++;
            run = 0;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic issue(input bit is_cmd, input bit also_act, input logic [7:0] op, input int len,
                         input bit wt, input bit we, input bit i2, input bit i3);
        @(negedge clk);
        act_req      = !is_cmd || also_act;
        cmd_req      = is_cmd;
        cmd_opcode   = op;
        cmd_len      = LW'(len);
        cmd_wip_wait = wt;
        cmd_wren     = we;
        cmd_io2      = i2;
        cmd_io3      = i3;
        @(negedge clk);
        act_req = 1'b0;
        cmd_req = 1'b0;
        chk_eq("R10", "busy after accept", int'(busy), 1);
    endtask

    task automatic wait_done(output bit got_rdy, output bit got_err);
        int r0 = rdy_cnt;
        int e0 = err_cnt;
        int n = 0;
        while (rdy_cnt == r0 && err_cnt == e0 && n < 20000) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
        got_rdy = (rdy_cnt != r0);
        got_err = (err_cnt != e0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual expired expected finished");
        summary();
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        bit g_r, g_e;
        int base, polls, total, last;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk_eq("R1", "cs_n in reset", int'(cs_n), 1);
        chk_eq("R1", "sck in reset", int'(sck), 0);
        chk_eq("R1", "busy/evt/err in reset", int'({busy, ready_evt, timeout_err}), 0);
        chk_eq("R1", "io2/io3 in reset", int'({io2, io3}), 3);
        rst_n = 1'b1;
        @(negedge clk);
        chk_eq("R1", "cs_n after reset", int'(cs_n), 1);
        chk_eq("R1", "busy after reset", int'(busy), 0);

        // Table-driven main function
        for (int v = 0; v < NV; v++) begin
            logic [20:0] e;
            bit k, wt, we, i2, i3;
            int ln, bp;
            logic [7:0] op;
            e  = VEC[v];
            k  = e[20]; op = e[19:12]; ln = int'(e[11:8]);
            wt = e[7];  we = e[6]; i2 = e[5]; i3 = e[4]; bp = int'(e[3:0]);
            busy_left = bp;
            base = nfr;
            issue(k, 1'b0, op, ln, wt, we, i2, i3);
            wait_done(g_r, g_e);
            polls = k ? (wt ? bp + 1 : 0) : bp + 1;
            total = polls + ((k && we) ? 1 : 0) + (k ? 1 : 0);
            chk_eq(k ? "R4" : "R3", "ready event", int'(g_r), 1);
            chk_eq("R7", "no error on healthy device", int'(g_e), 0);
            chk_eq(k ? "R4" : "R3", "frame count", nfr - base, total);
            for (int i = 0; i < polls; i++) begin
                chk_eq("R3", "poll opcode", fr_op[base + i], 8'h05);
                chk_eq("R3", "poll bytes", fr_nb[base + i], 2);
            end
            last = base + total - 1;
            if (k) begin
                if (we) begin
                    chk_eq("R5", "write-enable opcode", fr_op[last - 1], 8'h06);
                    chk_eq("R5", "write-enable bytes", fr_nb[last - 1], 1);
                end
                chk_eq("R6", "instruction opcode", fr_op[last], int'(op));
                chk_eq("R6", "instruction bytes", fr_nb[last], (ln == 0) ? 1 : ln);
                chk_eq("R12", "io levels during instruction", fr_io[last], int'({i2, i3}));
            end else begin
                chk_eq("R12", "io levels during activation", fr_io[last], 3);
            end
            repeat (100) @(negedge clk);
            chk_eq("R4", "no frame after completion", nfr - base, total);
            chk_eq("R12", "io idle levels", int'({io2, io3}), 3);
        end

        // R11: activation wins over simultaneous instruction
        busy_left = 0;
        base = nfr;
        issue(1'b1, 1'b1, 8'h9F, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        wait_done(g_r, g_e);
        chk_eq("R11", "priority frames", nfr - base, 1);
        chk_eq("R11", "priority opcode", fr_op[base], 8'h05);

        // R11: request during busy is ignored
        busy_left = 2;
        base = nfr;
        issue(1'b0, 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b1, 1'b1);
        repeat (20) @(negedge clk);
        cmd_opcode = 8'h9F; cmd_len = LW'(1); cmd_wip_wait = 1'b0; cmd_wren = 1'b0;
        cmd_req = 1'b1;
        @(negedge clk);
        cmd_req = 1'b0;
        wait_done(g_r, g_e);
        repeat (100) @(negedge clk);
        chk_eq("R11", "frames with ignored request", nfr - base, 3);
        chk_eq("R11", "last opcode with ignored request", fr_op[nfr - 1], 8'h05);
        chk_eq("R11", "idle after ignored request", int'(busy), 0);

        // R7: sleeping device makes the poll time out
        issue(1'b1, 1'b0, 8'hB9, 1, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_done(g_r, g_e);
        base = nfr;
        issue(1'b0, 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_done(g_r, g_e);
        chk_eq("R7", "timeout error", int'(g_e), 1);
        chk_eq("R7", "no ready on timeout", int'(g_r), 0);
        chk_ge("R7", "polls before timeout", nfr - base, 2);
        chk_eq("R10", "busy low after timeout", int'(busy), 0);

        // R8: wake, then the next frame waits out the quiet time
        issue(1'b1, 1'b0, 8'hAB, 1, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_done(g_r, g_e);
        chk_eq("R8", "wake ready", int'(g_r), 1);
        base = nfr;
        issue(1'b0, 1'b0, 8'h00, 0, 1'b0, 1'b0, 1'b1, 1'b1);
        wait_done(g_r, g_e);
        chk_eq("R8", "poll after wake ready", int'(g_r), 1);
        chk_ge("R8", "quiet time after wake", fr_gap[base], MIN_WAKE);

        // R9: minimum deselect gap across every logged frame
        begin
            int mg = 1 << 30;
            for (int i = 1; i < nfr; i++) if (fr_gap[i] < mg) mg = fr_gap[i];
            chk_ge("R9", "minimum deselect gap", mg, MIN_GAP);
        end

        // R2 and R10 pulse shapes
        chk_eq("R2", "sck high phase length violations", bad_run, 0);
        chk_ge("R2", "sck high phases seen", seen_runs, 8);
        chk_eq("R10", "event pulses longer than one cycle", wide_cnt, 0);

        summary();
        $finish;
    end

endmodule